// File: doc/BRIEF.md
# Parity-Selected Up/Down Three-Bit Counter

This block is a synchronous three-bit counter with one mode input that picks between two separate counting loops. With the mode input low, the counter walks upward through the even codes and wraps from six back to zero. With the mode input high, it leaves zero for seven and then steps downward through the odd codes until it comes back to zero. The flop contents drive the output directly, so the output word is the state.

Codes that do not belong to the loop chosen by the current mode still have fixed successors, taken from minimised next-state equations. They come up when the mode changes in the middle of a loop. Whatever the starting code, holding the mode steady brings the counter back to zero within a small, known number of clocks. Use the block where a small sequencer has to alternate between two interleaved code sets chosen by one control line.

Top module: `evenodd_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 000 at that edge, whatever the value of `odd_dn`.
- R2: With `odd_dn` low and an even current state, the next state is the current value plus 2 modulo 8, giving the loop 0, 2, 4, 6, 0.
- R3: With `odd_dn` high and a current state of 0 or any odd value, the next state follows the loop 0, 7, 5, 3, 1, 0.
- R4: With `odd_dn` low and an odd current state, the successors are fixed: 1 goes to 0, 3 to 4, 5 to 6 and 7 to 0.
- R5: With `odd_dn` high and a nonzero even current state, the successors are fixed: 2 goes to 5, 4 to 7 and 6 to 5.
- R6: `odd_dn` is sampled at the rising edge. A change of mode takes effect at the next edge and starts from whatever state the counter holds at that moment.
- R7: From any of the eight states, with `odd_dn` held constant, the state reaches 0 within 5 clocks. The longest path is from state 4 with `odd_dn` high: 4, 7, 5, 3, 1, 0.
- R8: `count_q` is the state word itself with no decoding. Bit 2 is the most significant bit, and the state number is the unsigned binary value of `count_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to state 000 |
| odd_dn | input | 1 | Mode: 0 selects the even up loop, 1 selects the odd down loop through zero |
| count_q | output | 3 | Current state, bit 2 most significant |

## Verification
The bench drives the mode line so that the counter lands in every one of the sixteen (mode, state) pairs, including the off-loop pairs that appear only after a mid-loop mode switch. A wrong term in the equations would send one of those pairs to the wrong successor. An inverted mode bit would swap the two loops, and a next-state path that ignores the register would stall. From each state the bench then holds the mode and counts the clocks back to zero. A recovery path that cycles, or the length-five path from state 4 made longer, would not meet the bound. It also raises reset while the mode line is high, which catches a reset that gives way to the counting logic.

// File: rtl/evenodd_pkg.sv
package evenodd_pkg;
  localparam int unsigned CW = 3;
  typedef logic [CW-1:0] code_t;

  // Minimised next-state equations; bit 2 is the most significant state bit.
  function automatic code_t next_code(input logic dn, input code_t s);
    code_t n;
    n[2] = dn ? ((s[2] & s[1]) | ~s[0]) : (s[2] ^ s[1]);
    n[1] = ~s[1] & (s[2] | ~s[0]);
    n[0] = dn & (s[2] | s[1] | ~s[0]);
    return n;
  endfunction
endpackage

// File: rtl/evenodd_next.sv
module evenodd_next
  import evenodd_pkg::*;
(
  input  logic  dn,
  input  code_t cur,
  output code_t nxt
);
  always_comb nxt = next_code(dn, cur);
endmodule

// File: rtl/evenodd_reg.sv
module evenodd_reg
  import evenodd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  code_t d,
  output code_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/evenodd_counter.sv
module evenodd_counter
  import evenodd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          odd_dn,
  output logic [CW-1:0] count_q
);
  code_t state_w;
  code_t next_w;
  logic  in_even_loop;
  logic  in_odd_loop;

  evenodd_next u_next (.dn(odd_dn), .cur(state_w), .nxt(next_w));
  evenodd_reg  u_reg  (.clk(clk), .rst(rst), .d(next_w), .q(state_w));

  assign count_q      = state_w;
  assign in_even_loop = ~odd_dn & ~state_w[0];
  assign in_odd_loop  = odd_dn & (state_w[0] | (state_w == '0));

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> count_q == '0);

  // R2
  even_step_chk: assert property (@(posedge clk) disable iff (rst)
    in_even_loop |=> count_q == code_t'($past(count_q) + 3'd2));

  // R3
  odd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_odd_loop && $past(1'b1) && count_q > 3'd1) |=> count_q == code_t'($past(count_q) - 3'd2));

  // R3
  odd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_odd_loop && count_q == 3'd0) |=> count_q == 3'd7);

  // R6
  even_mode_parity_chk: assert property (@(posedge clk) disable iff (rst)
    !odd_dn |=> !count_q[0]);

  // R5
  odd_mode_landing_chk: assert property (@(posedge clk) disable iff (rst)
    (odd_dn && !in_odd_loop) |=> (count_q == 3'd5 || count_q == 3'd7));
endmodule

// File: tb/sim_evenodd_counter.sv
`timescale 1ns/1ps
module sim_evenodd_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       odd_dn = 1'b0;
  logic [2:0] count_q;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] model = 3'd0;
  logic       last_c = 1'b0;

  always #2.5 clk = ~clk;

  evenodd_counter u0 (.clk(clk), .rst(rst), .odd_dn(odd_dn), .count_q(count_q));

  // Reference successor table written from the requirements.
  function automatic logic [2:0] ref_next(input logic [2:0] s, input logic c);
    case ({c, s})
      4'b0_000: return 3'd2;  4'b0_001: return 3'd0;
      4'b0_010: return 3'd4;  4'b0_011: return 3'd4;
      4'b0_100: return 3'd6;  4'b0_101: return 3'd6;
      4'b0_110: return 3'd0;  4'b0_111: return 3'd0;
      4'b1_000: return 3'd7;  4'b1_001: return 3'd0;
      4'b1_010: return 3'd5;  4'b1_011: return 3'd1;
      4'b1_100: return 3'd7;  4'b1_101: return 3'd3;
      4'b1_110: return 3'd5;  default:  return 3'd5;
    endcase
  endfunction

  function automatic string step_tag(input logic [2:0] s, input logic c, input logic changed);
    string t;
    if (!c) t = s[0] ? "R4" : "R2";
    else    t = (s[0] || s == 3'd0) ? "R3" : "R5";
    if (changed) t = {t, "/R6"};
    return {t, "/R8"};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: count_q=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic c);
    @(negedge clk);
    rst = 1'b1; odd_dn = c;
    model = 3'd0;
    exp_q.push_back(3'd0); tag_q.push_back("R1");
    @(posedge clk); #2;
  endtask

  task automatic do_step(input logic c);
    @(negedge clk);
    rst = 1'b0; odd_dn = c;
    tag_q.push_back(step_tag(model, c, c != last_c));
    model = ref_next(model, c);
    exp_q.push_back(model);
    last_c = c;
    @(posedge clk); #2;
  endtask

  // Monitor: compare each edge's result with the queued expectation.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(count_q === e, t, count_q, e);
      end
    end
  end

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog: count_q=%0d expected=finish", count_q);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [0:17] walk;
    do_reset(1'b1);
    do_reset(1'b1);
    // R2 even loop, then R3 odd loop
    for (int i = 0; i < 4; i++) do_step(1'b0);
    for (int i = 0; i < 5; i++) do_step(1'b1);
    // mode switches visiting every off-loop pair (R4, R5, R6)
    walk = 18'b0_1_0_1_1_0_1_0_1_1_1_1_0_0_0_0_1_1;
    foreach (walk[i]) do_step(walk[i]);
    // R1 reset with mode high mid-loop
    do_step(1'b1);
    do_reset(1'b1);
    // R7 bounded recovery from every state under each mode
    for (int cc = 0; cc < 2; cc++) begin
      for (int s = 0; s < 8; s++) begin
        int hit;
        do_reset(1'b0);
        if (s[0] == 1'b0) begin
          for (int k = 0; k < s / 2; k++) do_step(1'b0);
        end else begin
          for (int k = 0; k < (7 - s) / 2 + 1; k++) do_step(1'b1);
        end
        check(count_q === 3'(s), "R8 navigate", count_q, 3'(s));
        hit = 0;
        for (int k = 1; k <= 5; k++) begin
          do_step(cc[0]);
          if (hit == 0 && count_q == 3'd0) hit = k;
        end
        check(hit != 0, "R7", count_q, 3'd0);
      end
    end
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule